// File: doc/BRIEF.md
# Two-Channel Fine-Pulse PWM Digital-to-Analog Generator

This block turns a 14-bit code into a pulse train whose average level, after an external low-pass filter, is proportional to the code. A free-running 14-bit tick counter divides one conversion period of 16384 ticks into equal base cycles. A per-channel carrier bit picks the base cycle length: 64 ticks or 256 ticks. The upper part of the code sets how many ticks stay high in every base cycle. The lower part sets how many base cycles receive one extra high tick. These extra ticks are spread evenly by comparing the lower field with the bit-reversed index of the base cycle. Over a whole period, the number of high ticks therefore equals the code.

There are two channels, each with its own code and carrier bit, and both share the counter. A one-bit address and a page bit give access to four 16-bit words: the two data words on page 0, and a control word and a read-only counter word on page 1. Code and carrier changes wait until the current base cycle ends, so no base cycle is ever cut short. A code below the minimum for the chosen carrier holds the output low. When the two lowest code bits are zero, the channel works at 12-bit accuracy.

Top module: `pwm_dac14`

## Requirements
- R1: After reset the two codes are 0x3FFF, both carrier bits are 1, the page bit is 1, the run bit is 0 and both outputs are low. So address 0 reads 0xFFFE on page 0 and 0xFFFD on page 1, and address 1 reads 0x0003 on page 1.
- R2: Every write copies wdata[0] into the page bit. On page 0, address a (0 or 1) writes the code of channel a from wdata[15:2] and its carrier bit from wdata[1]. On page 1, a write to address 0 sets the run bit from wdata[1] and leaves the codes unchanged. The data words read back as {code, carrier, page}.
- R3: While run is 1, the counter advances by one every clock and wraps from 0x3FFF to 0. On page 1 it reads at address 1 as {counter, 1, page}.
- R4: With carrier 0, a base cycle is 64 ticks long, and each one is high for code[13:8] ticks plus an optional single extra tick.
- R5: With carrier 1, a base cycle is 256 ticks long, and each one is high for code[13:6] ticks plus an optional single extra tick.
- R6: Base cycle k receives the extra tick exactly when bit-reversed k is less than the lower field (code[7:0] with carrier 0, code[5:0] with carrier 1). Any 16384 consecutive ticks hold exactly code high ticks.
- R7: A code below 0x0100 with carrier 0, or below 0x0040 with carrier 1, holds the output low.
- R8: When code[1:0] is 00, any 4096 consecutive ticks hold exactly code/4 high ticks.
- R9: A new code or carrier bit takes effect only at the next base-cycle boundary of the channel. Until then the channel keeps producing the old pattern.
- R10: While run is 0, the counter stays at 0 and both outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; one tick is the resolution of the output |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 1 | Word address within the selected page |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed word (combinational) |
| pwm_out | output | 2 | Pulse outputs, bit i for channel i |

## Verification
The embedded assertions check the following on every clock:
- the counter steps by one or stays cleared while stopped;
- page-1 writes and idle cycles leave the codes untouched;
- an active setting never changes inside a base cycle;
- an out-of-range active code, or a stopped block, always gives a low output.

Only the bench scenarios can show that the duty arithmetic is right: the per-base-cycle high count in both carrier modes, the even spread of fine ticks so that a full period sums to the code, and the quarter-period sums when the code's two lowest bits are zero. The same holds for the visible delay of a mid-cycle code change until the next boundary.

// File: rtl/pwm_dac_pkg.sv
`timescale 1ns/1ps
package pwm_dac_pkg;

  // Tick counter / code width and carrier exponents.
  localparam int unsigned CNT_W     = 14;
  localparam int unsigned SHORT_LOG = 6;   // 64-tick base cycle
  localparam int unsigned LONG_LOG  = 8;   // 256-tick base cycle
  // Two channels, addressed by a one-bit word address.
  localparam int unsigned N_CH      = 2;
  localparam int unsigned REG_W     = CNT_W + 2;

  typedef struct packed {
    logic [CNT_W-1:0] code;
    logic             carrier;
  } ch_cfg_t;

  // Reverse the lowest w bits of v; bits above w come back as zero.
  function automatic logic [CNT_W-1:0] rev_low(input logic [CNT_W-1:0] v,
                                               input int unsigned w);
    logic [CNT_W-1:0] r;
    r = '0;
    for (int i = 0; i < CNT_W; i++) begin
      r = {r[CNT_W-2:0], v[i]};
    end
    return r >> (CNT_W - w);
  endfunction

endpackage

// File: rtl/pwm_dac_regs.sv
`timescale 1ns/1ps
module pwm_dac_regs
  import pwm_dac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  output logic [REG_W-1:0] rdata,
  output ch_cfg_t          cfg_o [N_CH],
  output logic             run_o
);

  ch_cfg_t cfg_q [N_CH];
  ch_cfg_t cfg_d [N_CH];
  logic    page_q, page_d;
  logic    run_q,  run_d;

  // Next-state logic
  always_comb begin
    for (int i = 0; i < N_CH; i++) cfg_d[i] = cfg_q[i];
    page_d = page_q;
    run_d  = run_q;
    if (wr_en) begin
      page_d = wdata[0];
      if (!page_q) begin
        cfg_d[addr].code    = wdata[REG_W-1:2];
        cfg_d[addr].carrier = wdata[1];
      end else if (addr == 1'b0) begin
        run_d = wdata[1];
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) begin
        cfg_q[i] <= '{code: '1, carrier: 1'b1};
      end
      page_q <= 1'b1;
      run_q  <= 1'b0;
    end else begin
      for (int i = 0; i < N_CH; i++) cfg_q[i] <= cfg_d[i];
      page_q <= page_d;
      run_q  <= run_d;
    end
  end

  // Read multiplexer
  always_comb begin
    if (!page_q) begin
      rdata = {cfg_q[addr].code, cfg_q[addr].carrier, page_q};
    end else if (addr == 1'b0) begin
      rdata = {{CNT_W{1'b1}}, run_q, page_q};
    end else begin
      rdata = {cnt, 1'b1, page_q};
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_out
    assign cfg_o[g] = cfg_q[g];
  end
  assign run_o = run_q;

  // R2: idle cycles change nothing
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cfg_q[0]) && $stable(cfg_q[1]) && $stable(page_q) && $stable(run_q)));

  // R2: page-1 writes never touch the codes
  a_r2_ctrl_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && page_q) |=> ($stable(cfg_q[0]) && $stable(cfg_q[1])));

endmodule

// File: rtl/pwm_dac_timebase.sv
`timescale 1ns/1ps
module pwm_dac_timebase
  import pwm_dac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (run) cnt_d = cnt_q + 1'b1;
    else     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3: one step per clock while running, wrapping at the top
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R10: cleared while stopped
  a_r10_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_dac_channel.sv
`timescale 1ns/1ps
module pwm_dac_channel
  import pwm_dac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  ch_cfg_t          cfg_in,
  output logic             pwm_o
);

  localparam int unsigned S_IDX_W = CNT_W - SHORT_LOG;
  localparam int unsigned L_IDX_W = CNT_W - LONG_LOG;
  localparam logic [CNT_W-1:0] S_LOW_MASK = CNT_W'((1 << S_IDX_W) - 1);
  localparam logic [CNT_W-1:0] L_LOW_MASK = CNT_W'((1 << L_IDX_W) - 1);
  localparam logic [CNT_W-1:0] S_TICK_MASK = CNT_W'((1 << SHORT_LOG) - 1);
  localparam logic [CNT_W-1:0] L_TICK_MASK = CNT_W'((1 << LONG_LOG) - 1);
  localparam logic [CNT_W-1:0] S_MIN_CODE = CNT_W'(1 << S_IDX_W);
  localparam logic [CNT_W-1:0] L_MIN_CODE = CNT_W'(1 << L_IDX_W);

  ch_cfg_t          act_q, act_d;
  logic             pwm_q, pwm_d;
  logic             last_tick, load;
  logic [CNT_W-1:0] upper, lower, tick, rev_idx;
  logic             extra, in_range, high;

  // End of the current base cycle, measured in the active carrier
  always_comb begin
    if (act_q.carrier) last_tick = ((cnt & L_TICK_MASK) == L_TICK_MASK);
    else               last_tick = ((cnt & S_TICK_MASK) == S_TICK_MASK);
  end

  assign load  = !run || last_tick;
  assign act_d = load ? cfg_in : act_q;

  // Field split for the active carrier
  always_comb begin
    if (act_q.carrier) begin
      upper   = act_q.code >> L_IDX_W;
      lower   = act_q.code & L_LOW_MASK;
      tick    = cnt & L_TICK_MASK;
      rev_idx = rev_low(cnt >> LONG_LOG, L_IDX_W);
    end else begin
      upper   = act_q.code >> S_IDX_W;
      lower   = act_q.code & S_LOW_MASK;
      tick    = cnt & S_TICK_MASK;
      rev_idx = rev_low(cnt >> SHORT_LOG, S_IDX_W);
    end
  end

  assign extra    = (rev_idx < lower);
  assign in_range = (upper != '0);
  assign high     = (tick < upper) || ((tick == upper) && extra);
  assign pwm_d    = run && in_range && high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '{code: '1, carrier: 1'b1};
      pwm_q <= 1'b0;
    end else begin
      act_q <= act_d;
      pwm_q <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;

  // Range limit written from the code value, not from the field split
  logic code_ok;
  assign code_ok = act_q.carrier ? (act_q.code >= L_MIN_CODE) : (act_q.code >= S_MIN_CODE);

  // R9: the active setting is frozen inside a running base cycle
  a_r9_defer: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last_tick) |=> $stable(act_q));

  // R7: out-of-range code keeps the output low
  a_r7_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ok |=> !pwm_q);

  // R10: stopped block keeps the output low
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pwm_q);

endmodule

// File: rtl/pwm_dac14.sv
`timescale 1ns/1ps
module pwm_dac14
  import pwm_dac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [N_CH-1:0]  pwm_out
);

  // Asynchronous assert, synchronous release
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ch_cfg_t          cfg [N_CH];
  logic             run;
  logic [CNT_W-1:0] cnt;

  pwm_dac_regs u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .cnt   (cnt),
    .rdata (rdata),
    .cfg_o (cfg),
    .run_o (run)
  );

  pwm_dac_timebase u_timebase (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .cnt   (cnt)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pwm_dac_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .run    (run),
      .cnt    (cnt),
      .cfg_in (cfg[g]),
      .pwm_o  (pwm_out[g])
    );
  end

endmodule

// File: tb/test_pwm_dac14.sv
`timescale 1ns/1ps
module test_pwm_dac14;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 300;
  localparam int PERIOD     = 16384;

  typedef struct packed {
    logic        c0;
    logic [13:0] d0;
    logic [14:0] e0;
    logic        c1;
    logic [13:0] d1;
    logic [14:0] e1;
  } vec_t;

  // carrier, code, expected high ticks per full period (per channel)
  localparam vec_t VECS [5] = '{
    '{1'b0, 14'h0100, 15'd256,   1'b1, 14'h0040, 15'd64},
    '{1'b0, 14'h1234, 15'h1234,  1'b1, 14'h2ABD, 15'h2ABD},
    '{1'b0, 14'h3FFF, 15'd16383, 1'b1, 14'h3FFF, 15'd16383},
    '{1'b0, 14'h00FF, 15'd0,     1'b1, 14'h003F, 15'd0},
    '{1'b0, 14'h0040, 15'd0,     1'b1, 14'h0100, 15'd256}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  pwm_out;

  int n_cmp = 0;
  int n_err = 0;

  pwm_dac14 i_pwm_dac14 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pwm_out (pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(input int n, output int h0, output int h1);
    h0 = 0;
    h1 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h0 += int'(pwm_out[0]);
      h1 += int'(pwm_out[1]);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int h0, h1, c_a, c_b;
    rst_n = 1'b0;
    wr_en = 1'b0;
    addr  = 1'b0;
    wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, page 1 visible
    addr = 1'b0; #1;
    check("R1 control word", int'(rdata), 16'hFFFD);
    addr = 1'b1; #1;
    check("R1 counter word", int'(rdata), 16'h0003);
    check("R1 outputs low", int'(pwm_out), 0);

    // R2: page switch via control write, codes intact
    wr(1'b0, 16'h0000);
    addr = 1'b0; #1;
    check("R1 code0 reset", int'(rdata), 16'hFFFE);
    addr = 1'b1; #1;
    check("R1 code1 reset", int'(rdata), 16'hFFFE);

    // R10: stopped with a valid code -> low
    count_high(100, h0, h1);
    check("R10 ch0 low while stopped", h0, 0);
    check("R10 ch1 low while stopped", h1, 0);
    wr(1'b0, {14'h3FFF, 1'b1, 1'b1});
    addr = 1'b1; #1;
    check("R10 counter held at 0", int'(rdata), 16'h0003);

    // R3: start and observe counter progress
    wr(1'b0, 16'h0003);
    addr = 1'b1; #1;
    c_a = int'(rdata[15:2]);
    repeat (10) @(negedge clk);
    c_b = int'(rdata[15:2]);
    check("R3 counter advance", (c_b - c_a) & 16'h3FFF, 10);
    wr(1'b0, 16'h0002);
    addr = 1'b0; #1;
    check("R2 back on data page", int'(rdata), 16'hFFFE);

    // R6 / R7: vector table, full-period sums
    foreach (VECS[v]) begin
      wr(1'b0, {VECS[v].d0, VECS[v].c0, 1'b0});
      wr(1'b1, {VECS[v].d1, VECS[v].c1, 1'b0});
      repeat (SETTLE) @(negedge clk);
      count_high(PERIOD, h0, h1);
      check(VECS[v].e0 == 0 ? "R7 ch0 range" : "R6 ch0 period sum", h0, int'(VECS[v].e0));
      check(VECS[v].e1 == 0 ? "R7 ch1 range" : "R6 ch1 period sum", h1, int'(VECS[v].e1));
    end

    // R2: readback of a written data word
    addr = 1'b1; #1;
    check("R2 code1 readback", int'(rdata), {14'h0100, 1'b1, 1'b0});

    // R4 / R5: base-cycle duty, no fine ticks
    wr(1'b0, {14'h0500, 1'b0, 1'b0});
    wr(1'b1, {14'h0140, 1'b1, 1'b0});
    repeat (SETTLE) @(negedge clk);
    count_high(256, h0, h1);
    check("R4 short carrier 4 cycles x 5", h0, 20);
    check("R5 long carrier 1 cycle x 5", h1, 5);

    // R8: 12-bit codes, quarter-period sums
    wr(1'b0, {14'h1234, 1'b0, 1'b0});
    wr(1'b1, {14'h2AB0, 1'b1, 1'b0});
    repeat (SETTLE) @(negedge clk);
    count_high(4096, h0, h1);
    check("R8 ch0 quarter sum", h0, 14'h1234 / 4);
    check("R8 ch1 quarter sum", h1, 14'h2AB0 / 4);

    // R9: mid-cycle change waits for the boundary
    wr(1'b0, {14'h0100, 1'b0, 1'b0});
    repeat (SETTLE) @(negedge clk);
    wr(1'b0, {14'h0100, 1'b0, 1'b1});
    addr = 1'b1;
    #1;
    while (rdata[7:2] != 6'd8) @(negedge clk);
    wr(1'b0, 16'h0002);
    wr(1'b0, {14'h3F00, 1'b0, 1'b0});
    count_high(40, h0, h1);
    check("R9 old pattern kept", h0, 0);
    repeat (30) @(negedge clk);
    count_high(64, h0, h1);
    check("R9 new pattern after boundary", h0, 63);

    // R10: stop again
    wr(1'b0, {14'h3F00, 1'b0, 1'b1});
    wr(1'b0, 16'h0001);
    repeat (2) @(negedge clk);
    count_high(50, h0, h1);
    check("R10 outputs low after stop", h0 + h1, 0);
    addr = 1'b1; #1;
    check("R10 counter cleared", int'(rdata), 16'h0003);

    summary();
    $finish;
  end

endmodule